// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block steps a 16-bit processor core into and out of interrupt service. At an instruction boundary the core presents either a pending interrupt (a 3-bit level plus an 8-bit vector) or a return-from-interrupt command from its decoder. The sequencer takes a snapshot of the status word, program counter and supervisor stack pointer and stalls fetch. It then runs a short series of single-cycle memory accesses on the shared port. When the series ends, it writes all three core registers back in one cycle.

An interrupt is admitted when the level in the status word does not exceed the requested level. On entry the old status word and program counter go onto the supervisor stack, and the handler address comes from a vector table. The status word becomes privileged at the requested level. A return pops the same two words in the opposite order. The return is legal only in privileged mode; issued from user mode it raises a privilege fault and changes nothing.

Top module: `irq_seq`

## Requirements
- R1: A request sampled while the status level (PSR bits 10:8) is strictly greater than the requested level is rejected. Any other request is accepted, including one at an equal level. Exactly one of `accept_o` and `reject_o` pulses for one cycle, in the cycle after the sampling edge. A rejected request changes no register and makes no memory access.
- R2: Requests are sampled only while the sequencer is idle and `boundary_i` is high. `irq_req_i` or `rti_i` without `boundary_i` has no effect. When both are present at a boundary, the return is served and the interrupt is not answered.
- R3: Entry first writes the old PSR to address SP-1 and then, in the next cycle, writes the old PC to SP-2. Each write is held for one cycle.
- R4: Entry then reads address 0x0100 plus the zero-extended vector, and the returned word becomes the new PC.
- R5: After entry, the PSR holds 0 in bit 15, the requested level in bits 10:8 and 0 in every other bit. SP holds the old SP minus 2.
- R6: A return in privileged mode (PSR bit 15 = 0) reads the new PC from SP, then reads the new PSR from SP+1, then sets SP to SP+2.
- R7: A return with PSR bit 15 = 1 pulses `priv_fault_o` for one cycle in the cycle after sampling. It makes no memory access and writes no register.
- R8: Each read request lasts one cycle. The sequencer waits for `mem_rvalid_i` before it uses the data. At the end of a sequence, PSR, PC and SP are written together in the single cycle in which `done_o` pulses.
- R9: `stall_o` is high from the cycle after an admitted request through the `done_o` cycle, and low otherwise. No memory request is made while `stall_o` is low.
- R10: During and after reset the sequencer is idle. No pulse, memory request or register write is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary_i | input | 1 | Core is at an instruction boundary |
| irq_req_i | input | 1 | Interrupt request pending |
| irq_lvl_i | input | 3 | Requested priority level |
| irq_vec_i | input | 8 | Interrupt vector |
| rti_i | input | 1 | Return-from-interrupt decoded |
| psr_i | input | 16 | Current status word |
| pc_i | input | 16 | Current program counter |
| sp_i | input | 16 | Current supervisor stack pointer (R6) |
| psr_we_o | output | 1 | Status word write enable |
| psr_o | output | 16 | New status word |
| pc_we_o | output | 1 | Program counter write enable |
| pc_o | output | 16 | New program counter |
| sp_we_o | output | 1 | Stack pointer write enable |
| sp_o | output | 16 | New stack pointer |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_rdata_i | input | 16 | Memory read data |
| mem_rvalid_i | input | 1 | Read data valid |
| accept_o | output | 1 | Interrupt accepted pulse |
| reject_o | output | 1 | Interrupt rejected pulse |
| priv_fault_o | output | 1 | Return attempted in user mode |
| done_o | output | 1 | Sequence complete, registers written |
| stall_o | output | 1 | Hold core fetch |

## Verification
The assertions watch the protocol on every cycle. They check that at most one outcome pulse fires and that rejects and faults leave the port and the stall quiet. They also check that each read lasts one cycle and that the two pushes come back to back. Register writes must appear only together with read data, and the stall must drop right after `done_o`. Only the bench's scenarios can show the data: the priority comparison at lower, equal and higher levels, the exact stacked words and their addresses, the vector table address, the rebuilt status word, and a full entry-then-return round trip that restores the original state.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PUSH_PSR,
        ST_PUSH_PC,
        ST_VEC_RD,
        ST_VEC_WAIT,
        ST_POP_PC_RD,
        ST_POP_PC_WAIT,
        ST_POP_PSR_RD,
        ST_POP_PSR_WAIT
    } seq_state_e;

endpackage

// File: rtl/irq_prio_gate.sv
module irq_prio_gate #(
    parameter int unsigned LVL_W = 3
) (
    input  logic [LVL_W-1:0] cur_lvl_i,
    input  logic [LVL_W-1:0] req_lvl_i,
    output logic             admit_o
);
    // equal level is admitted; only a strictly higher current level blocks
    always_comb begin
        admit_o = !(cur_lvl_i > req_lvl_i);
    end
endmodule

// File: rtl/irq_addr_gen.sv
module irq_addr_gen
    import irq_seq_pkg::*;
#(
    parameter int unsigned          WORD_W   = 16,
    parameter int unsigned          VEC_W    = 8,
    parameter logic [WORD_W-1:0]    VEC_BASE = 16'h0100
) (
    input  seq_state_e        state_i,
    input  logic [WORD_W-1:0] sp_i,
    input  logic [VEC_W-1:0]  vec_i,
    output logic              req_o,
    output logic              we_o,
    output logic [WORD_W-1:0] addr_o
);
    localparam logic [WORD_W-1:0] ONE = WORD_W'(1);
    localparam logic [WORD_W-1:0] TWO = WORD_W'(2);

    always_comb begin
        req_o  = 1'b0;
        we_o   = 1'b0;
        addr_o = '0;
        unique case (state_i)
            ST_PUSH_PSR: begin
                req_o  = 1'b1;
                we_o   = 1'b1;
                addr_o = sp_i - ONE;
            end
            ST_PUSH_PC: begin
                req_o  = 1'b1;
                we_o   = 1'b1;
                addr_o = sp_i - TWO;
            end
            ST_VEC_RD: begin
                req_o  = 1'b1;
                addr_o = VEC_BASE + WORD_W'(vec_i);
            end
            ST_POP_PC_RD: begin
                req_o  = 1'b1;
                addr_o = sp_i;
            end
            ST_POP_PSR_RD: begin
                req_o  = 1'b1;
                addr_o = sp_i + ONE;
            end
            default: begin
                req_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/irq_psr_build.sv
module irq_psr_build #(
    parameter int unsigned WORD_W   = 16,
    parameter int unsigned LVL_W    = 3,
    parameter int unsigned PRIO_LSB = 8
) (
    input  logic [LVL_W-1:0]  lvl_i,
    output logic [WORD_W-1:0] psr_o
);
    // privileged (top bit 0), level in its field, all else cleared
    always_comb begin
        psr_o = '0;
        psr_o[PRIO_LSB +: LVL_W] = lvl_i;
    end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import irq_seq_pkg::*;
#(
    parameter int unsigned       WORD_W   = 16,
    parameter int unsigned       LVL_W    = 3,
    parameter int unsigned       VEC_W    = 8,
    parameter int unsigned       PRIO_LSB = 8,
    parameter int unsigned       PRIV_BIT = 15,
    parameter logic [WORD_W-1:0] VEC_BASE = 16'h0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boundary_i,
    input  logic              irq_req_i,
    input  logic [LVL_W-1:0]  irq_lvl_i,
    input  logic [VEC_W-1:0]  irq_vec_i,
    input  logic              rti_i,
    input  logic [WORD_W-1:0] psr_i,
    input  logic [WORD_W-1:0] pc_i,
    input  logic [WORD_W-1:0] sp_i,
    output logic              psr_we_o,
    output logic [WORD_W-1:0] psr_o,
    output logic              pc_we_o,
    output logic [WORD_W-1:0] pc_o,
    output logic              sp_we_o,
    output logic [WORD_W-1:0] sp_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [WORD_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic              mem_rvalid_i,
    output logic              accept_o,
    output logic              reject_o,
    output logic              priv_fault_o,
    output logic              done_o,
    output logic              stall_o
);
    localparam logic [WORD_W-1:0] SP_STEP = WORD_W'(2);

    typedef struct packed {
        seq_state_e        state;
        logic [WORD_W-1:0] sp;
        logic [WORD_W-1:0] psr;
        logic [WORD_W-1:0] pc;
        logic [WORD_W-1:0] tmp;
        logic [LVL_W-1:0]  lvl;
        logic [VEC_W-1:0]  vec;
        logic              accept;
        logic              reject;
        logic              fault;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic              admit;
    logic [WORD_W-1:0] entry_psr;

    irq_prio_gate #(
        .LVL_W (LVL_W)
    ) u_gate (
        .cur_lvl_i (psr_i[PRIO_LSB +: LVL_W]),
        .req_lvl_i (irq_lvl_i),
        .admit_o   (admit)
    );

    irq_psr_build #(
        .WORD_W   (WORD_W),
        .LVL_W    (LVL_W),
        .PRIO_LSB (PRIO_LSB)
    ) u_psr (
        .lvl_i (r_q.lvl),
        .psr_o (entry_psr)
    );

    irq_addr_gen #(
        .WORD_W   (WORD_W),
        .VEC_W    (VEC_W),
        .VEC_BASE (VEC_BASE)
    ) u_addr (
        .state_i (r_q.state),
        .sp_i    (r_q.sp),
        .vec_i   (r_q.vec),
        .req_o   (mem_req_o),
        .we_o    (mem_we_o),
        .addr_o  (mem_addr_o)
    );

    always_comb begin
        r_d        = r_q;
        r_d.accept = 1'b0;
        r_d.reject = 1'b0;
        r_d.fault  = 1'b0;

        psr_we_o    = 1'b0;
        pc_we_o     = 1'b0;
        sp_we_o     = 1'b0;
        psr_o       = '0;
        pc_o        = '0;
        sp_o        = '0;
        done_o      = 1'b0;
        mem_wdata_o = '0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (boundary_i && rti_i) begin
                    if (psr_i[PRIV_BIT]) begin
                        r_d.fault = 1'b1;
                    end else begin
                        r_d.sp    = sp_i;
                        r_d.state = ST_POP_PC_RD;
                    end
                end else if (boundary_i && irq_req_i) begin
                    if (admit) begin
                        r_d.accept = 1'b1;
                        r_d.psr    = psr_i;
                        r_d.pc     = pc_i;
                        r_d.sp     = sp_i;
                        r_d.lvl    = irq_lvl_i;
                        r_d.vec    = irq_vec_i;
                        r_d.state  = ST_PUSH_PSR;
                    end else begin
                        r_d.reject = 1'b1;
                    end
                end
            end
            ST_PUSH_PSR: begin
                mem_wdata_o = r_q.psr;
                r_d.state   = ST_PUSH_PC;
            end
            ST_PUSH_PC: begin
                mem_wdata_o = r_q.pc;
                r_d.state   = ST_VEC_RD;
            end
            ST_VEC_RD: begin
                r_d.state = ST_VEC_WAIT;
            end
            ST_VEC_WAIT: begin
                if (mem_rvalid_i) begin
                    pc_we_o   = 1'b1;
                    pc_o      = mem_rdata_i;
                    psr_we_o  = 1'b1;
                    psr_o     = entry_psr;
                    sp_we_o   = 1'b1;
                    sp_o      = r_q.sp - SP_STEP;
                    done_o    = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            ST_POP_PC_RD: begin
                r_d.state = ST_POP_PC_WAIT;
            end
            ST_POP_PC_WAIT: begin
                if (mem_rvalid_i) begin
                    r_d.tmp   = mem_rdata_i;
                    r_d.state = ST_POP_PSR_RD;
                end
            end
            ST_POP_PSR_RD: begin
                r_d.state = ST_POP_PSR_WAIT;
            end
            ST_POP_PSR_WAIT: begin
                if (mem_rvalid_i) begin
                    pc_we_o   = 1'b1;
                    pc_o      = r_q.tmp;
                    psr_we_o  = 1'b1;
                    psr_o     = mem_rdata_i;
                    sp_we_o   = 1'b1;
                    sp_o      = r_q.sp + SP_STEP;
                    done_o    = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign accept_o     = r_q.accept;
    assign reject_o     = r_q.reject;
    assign priv_fault_o = r_q.fault;
    assign stall_o      = (r_q.state != ST_IDLE);

endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic accept_o,
    input logic reject_o,
    input logic priv_fault_o,
    input logic done_o,
    input logic stall_o,
    input logic mem_req_o,
    input logic mem_we_o,
    input logic mem_rvalid_i,
    input logic psr_we_o,
    input logic pc_we_o,
    input logic sp_we_o
);
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({accept_o, reject_o, priv_fault_o})); // R1
    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        reject_o |-> !stall_o && !mem_req_o); // R1
    AST_SINGLE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> !reject_o && !priv_fault_o); // R2
    AST_PUSH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_o) |=> mem_req_o && mem_we_o); // R3
    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        priv_fault_o |-> !stall_o && !mem_req_o && !psr_we_o && !pc_we_o && !sp_we_o); // R7
    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o) |=> !mem_req_o); // R8
    AST_WRITE_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (psr_we_o || pc_we_o || sp_we_o) |-> mem_rvalid_i && stall_o); // R8
    AST_DONE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> psr_we_o && pc_we_o && sp_we_o); // R8
    AST_ACCEPT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> stall_o); // R9
    AST_IDLE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_o |-> !mem_req_o); // R9
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !stall_o); // R9
    always_comb begin
        if (!rst_n) begin
            AST_RESET_IDLE: assert (!mem_req_o && !psr_we_o && !pc_we_o && !sp_we_o); // R10
        end
    end
endmodule

bind irq_seq irq_seq_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept_o     (accept_o),
    .reject_o     (reject_o),
    .priv_fault_o (priv_fault_o),
    .done_o       (done_o),
    .stall_o      (stall_o),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_rvalid_i (mem_rvalid_i),
    .psr_we_o     (psr_we_o),
    .pc_we_o      (pc_we_o),
    .sp_we_o      (sp_we_o)
);

// File: tb/test_irq_seq.sv
`timescale 1ns/1ps
module test_irq_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boundary_i = 1'b0, irq_req_i = 1'b0, rti_i = 1'b0;
    logic [2:0]  irq_lvl_i = '0;
    logic [7:0]  irq_vec_i = '0;
    logic [15:0] psr_r = '0, pc_r = '0, sp_r = '0;
    logic        psr_we_o, pc_we_o, sp_we_o;
    logic [15:0] psr_o, pc_o, sp_o;
    logic        mem_req_o, mem_we_o;
    logic [15:0] mem_addr_o, mem_wdata_o;
    logic [15:0] rdata = '0;
    logic        rvalid = 1'b0;
    logic        accept_o, reject_o, priv_fault_o, done_o, stall_o;

    logic        ld_en = 1'b0;
    logic [15:0] ld_psr = '0, ld_pc = '0, ld_sp = '0;
    int          wr_cnt = 0, rd_cnt = 0;
    int          checks = 0, errors = 0;

    logic [15:0] mem [logic [15:0]];
    logic        pend = 1'b0;
    logic [15:0] paddr = '0;
    int          lat = 0;

    always #2.5 clk = ~clk;

    irq_seq i_irq_seq (
        .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .irq_req_i(irq_req_i),
        .irq_lvl_i(irq_lvl_i), .irq_vec_i(irq_vec_i), .rti_i(rti_i),
        .psr_i(psr_r), .pc_i(pc_r), .sp_i(sp_r),
        .psr_we_o(psr_we_o), .psr_o(psr_o), .pc_we_o(pc_we_o), .pc_o(pc_o),
        .sp_we_o(sp_we_o), .sp_o(sp_o),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(rdata), .mem_rvalid_i(rvalid),
        .accept_o(accept_o), .reject_o(reject_o), .priv_fault_o(priv_fault_o),
        .done_o(done_o), .stall_o(stall_o)
    );

    function automatic logic [15:0] fill(input logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h5A3C;
    endfunction

    function automatic logic [15:0] rd(input logic [15:0] a);
        if (mem.exists(a)) return mem[a];
        return fill(a);
    endfunction

    function automatic logic admit(input logic [15:0] psr, input logic [2:0] lvl);
        return !(psr[10:8] > lvl);
    endfunction

    // core register file and memory model
    always @(posedge clk) begin
        if (ld_en) begin
            psr_r <= ld_psr; pc_r <= ld_pc; sp_r <= ld_sp;
        end else begin
            if (psr_we_o) psr_r <= psr_o;
            if (pc_we_o)  pc_r  <= pc_o;
            if (sp_we_o)  sp_r  <= sp_o;
        end
        if (mem_req_o && mem_we_o) begin
            mem[mem_addr_o] = mem_wdata_o;
            wr_cnt <= wr_cnt + 1;
        end
    end

    // read responder with variable latency
    always @(posedge clk) begin
        rvalid <= 1'b0;
        if (pend) begin
            if (lat == 0) begin
                rvalid <= 1'b1;
                rdata  <= rd(paddr);
                pend   <= 1'b0;
            end else begin
                lat <= lat - 1;
            end
        end else if (mem_req_o && !mem_we_o) begin
            pend   <= 1'b1;
            paddr  <= mem_addr_o;
            lat    <= $urandom_range(0, 2);
            rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [15:0] p, input logic [15:0] c, input logic [15:0] s);
        @(negedge clk);
        ld_psr = p; ld_pc = c; ld_sp = s; ld_en = 1'b1;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done_o && n < 60) begin
            @(negedge clk);
            n++;
        end
        chk(done_o, "R8 done", 16'(done_o), 16'h1);
        @(negedge clk);
    endtask

    task automatic do_entry(input logic [15:0] p0, input logic [15:0] c0, input logic [15:0] s0,
                            input logic [2:0] lvl, input logic [7:0] vec);
        logic exp_ok;
        int   w0;
        load(p0, c0, s0);
        exp_ok = admit(p0, lvl);
        w0 = wr_cnt;
        boundary_i = 1'b1; irq_req_i = 1'b1; irq_lvl_i = lvl; irq_vec_i = vec;
        @(negedge clk);
        boundary_i = 1'b0; irq_req_i = 1'b0;
        chk(accept_o == exp_ok,  "R1 accept", 16'(accept_o), 16'(exp_ok));
        chk(reject_o == !exp_ok, "R1 reject", 16'(reject_o), 16'(!exp_ok));
        if (exp_ok) begin
            chk(stall_o == 1'b1, "R9 stall on accept", 16'(stall_o), 16'h1);
            wait_done();
            chk(pc_r == fill(16'h0100 + 16'(vec)), "R4 vector pc", pc_r, fill(16'h0100 + 16'(vec)));
            chk(psr_r == {5'b0, lvl, 8'b0}, "R5 psr", psr_r, {5'b0, lvl, 8'b0});
            chk(sp_r == s0 - 16'd2, "R5 sp", sp_r, s0 - 16'd2);
            chk(rd(s0 - 16'd1) == p0, "R3 stacked psr", rd(s0 - 16'd1), p0);
            chk(rd(s0 - 16'd2) == c0, "R3 stacked pc", rd(s0 - 16'd2), c0);
            chk(stall_o == 1'b0, "R9 stall released", 16'(stall_o), 16'h0);
        end else begin
            repeat (3) @(negedge clk);
            chk(psr_r == p0 && pc_r == c0 && sp_r == s0, "R1 reject no change", pc_r, c0);
            chk(wr_cnt == w0 && !stall_o, "R1 reject no access", 16'(wr_cnt), 16'(w0));
        end
    endtask

    task automatic do_rti(input logic with_irq);
        logic        fault;
        logic [15:0] p0, c0, s0, ep, ec;
        int          w0, r0;
        p0 = psr_r; c0 = pc_r; s0 = sp_r;
        fault = p0[15];
        ec = rd(s0); ep = rd(s0 + 16'd1);
        w0 = wr_cnt; r0 = rd_cnt;
        boundary_i = 1'b1; rti_i = 1'b1; irq_req_i = with_irq; irq_lvl_i = 3'd7;
        @(negedge clk);
        boundary_i = 1'b0; rti_i = 1'b0; irq_req_i = 1'b0;
        chk(priv_fault_o == fault, "R7 fault pulse", 16'(priv_fault_o), 16'(fault));
        chk(accept_o == 1'b0, "R2 return wins", 16'(accept_o), 16'h0);
        if (fault) begin
            repeat (3) @(negedge clk);
            chk(psr_r == p0 && pc_r == c0 && sp_r == s0, "R7 no change", psr_r, p0);
            chk(wr_cnt == w0 && rd_cnt == r0, "R7 no access", 16'(rd_cnt), 16'(r0));
        end else begin
            wait_done();
            chk(pc_r == ec, "R6 pc pop", pc_r, ec);
            chk(psr_r == ep, "R6 psr pop", psr_r, ep);
            chk(sp_r == s0 + 16'd2, "R6 sp", sp_r, s0 + 16'd2);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!mem_req_o && !stall_o && !accept_o && !reject_o && !done_o, "R10 reset idle",
            16'(mem_req_o), 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_req_o && !stall_o && !psr_we_o, "R10 after reset", 16'(stall_o), 16'h0);

        // R1 equal, lower, higher levels
        do_entry(16'h0400, 16'h1234, 16'h3000, 3'd4, 8'h21);
        do_entry(16'h0500, 16'h2222, 16'h3000, 3'd4, 8'h22);
        do_entry(16'h8300, 16'h4444, 16'h3100, 3'd6, 8'h00);
        do_entry(16'h0000, 16'h5555, 16'h3200, 3'd0, 8'hFF);

        // R2 request without boundary is ignored
        load(16'h0000, 16'h7000, 16'h3300);
        irq_req_i = 1'b1; irq_lvl_i = 3'd7; rti_i = 1'b0;
        @(negedge clk);
        irq_req_i = 1'b0;
        @(negedge clk);
        chk(!accept_o && !reject_o && !stall_o && pc_r == 16'h7000, "R2 no boundary", pc_r, 16'h7000);

        // R6 round trip after an entry
        do_entry(16'h8207, 16'hBEEF, 16'h3400, 3'd5, 8'h40);
        do_rti(1'b0);
        chk(psr_r == 16'h8207 && pc_r == 16'hBEEF && sp_r == 16'h3400, "R6 round trip", pc_r, 16'hBEEF);

        // R7 user-mode return faults
        load(16'h8001, 16'h6000, 16'h5000);
        do_rti(1'b0);
        // R2 precedence: privileged return together with an interrupt
        load(16'h0000, 16'h6100, 16'h5010);
        do_rti(1'b1);

        for (int i = 0; i < 60; i++) begin
            logic [15:0] p, c, s;
            logic [2:0]  l;
            logic [7:0]  v;
            p = 16'($urandom);
            c = 16'($urandom);
            s = 16'h3000 + 16'($urandom_range(16, 4000));
            l = 3'($urandom_range(0, 7));
            v = 8'($urandom);
            do_entry(p, c, s, l, v);
            if (admit(p, l) && ($urandom_range(0, 1) == 1)) begin
                do_rti(1'b0);
                chk(psr_r == p && pc_r == c && sp_r == s, "R6 random round trip", psr_r, p);
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule